// File: doc/BRIEF.md
# APB Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on an APB bus as a slave. Software loads a start value, enables counting, and the counter steps down by one per count tick. When the counter steps from one to zero, an interrupt status bit can be set. That bit drives a level interrupt line until software writes a one to clear it. After reaching zero, the counter holds zero for one more tick and then reloads from the reload register. The period between interrupts is therefore the reload value plus one ticks.

A count tick is normally every bus clock cycle. An external input can also take part in counting. It can act as a level gate, where counting pauses while the input is low. It can also act as a slow count clock, where one tick occurs per rising edge. In both uses the input first passes through a two-flop synchroniser. A small set of read-only identification bytes sits at the top of the 4 KB register window.

Top module: `apb_interval_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers all read 0, and the interrupt output is low.
- R2: The control register is at offset 0x000 and stores only bits [3:0]: bit 0 run, bit 1 external gate, bit 2 external clock, bit 3 interrupt enable. Bits [31:4] read as 0.
- R3: While run is set and neither external mode is selected, the count value (offset 0x004) decreases by one on every clock cycle.
- R4: A write to the reload register (offset 0x008) sets both the reload value and the count value. A write to offset 0x004 changes only the count value.
- R5: The status bit is set when the count steps from 1 to 0 with interrupt enable set. With interrupt enable clear, no status is raised.
- R6: After reaching 0, the counter holds 0 for one tick and then reloads. Successive interrupts are therefore reload+1 ticks apart.
- R7: With a reload value of 0, the counter stays at 0 and never raises an interrupt.
- R8: In external gate mode, the counter does not decrement while the synchronised external input is low. It decrements every cycle while the input is high.
- R9: In external clock mode, the counter decrements once per rising edge of the synchronised external input.
- R10: The status register is at offset 0x00C, bit 0. Writing 1 clears the bit and writing 0 has no effect. The interrupt output equals this bit. If a set and a clear fall in the same cycle, the set wins.
- R11: The word offsets 0xFD0 to 0xFFC read the bytes 04,00,00,00,22,B8,1B,00,0D,F0,05,B1 (hex) in address order. Writes to them are ignored.
- R12: Unmapped or unaligned offsets read 0 and ignore writes. The ready output is always 1 and the error output always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered in the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | Asynchronous external gate or clock |
| irq | output | 1 | Level interrupt |

## Verification
The counter's one-to-zero step can set the status bit in the same cycle that a bus write clears it. The bench provokes this by starting the timer with a reload of 5 with interrupts enabled. It then times a write of 1 to the status register so that its access edge lands exactly on the fifth tick. The interrupt must still read high afterwards, and a later clear must then drop it. A second overlap is a bus write to the counter or reload register arriving in a tick cycle. This is judged by the exact count read back after a timed stop.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ID_LO  = 12'hFD0;

  localparam int unsigned ID_COUNT = 12;

  typedef struct packed {
    logic irq_en;
    logic ext_clk;
    logic ext_gate;
    logic run;
  } tmr_ctrl_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h22;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic ext_lvl,
  output logic ext_rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign ext_lvl  = sync_q[STAGES-1];
  assign ext_rise = sync_q[STAGES-1] & ~prev_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctrl_t        ctrl,
  input  logic             ext_lvl,
  input  logic             ext_rise,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic             clr_stat,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic tick;
  logic bus_load;
  logic hit_zero;

  always_comb begin
    tick     = ctrl.run & (~ctrl.ext_gate | ext_lvl) & (~ctrl.ext_clk | ext_rise);
    bus_load = wr_count | wr_reload;
    hit_zero = tick & ~bus_load & (count == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_reload) begin
        reload <= wdata;
        count  <= wdata;
      end else if (wr_count) begin
        count <= wdata;
      end else if (tick) begin
        count <= (count == '0) ? reload : count - ONE;
      end
      if (hit_zero && ctrl.irq_en) irq <= 1'b1;
      else if (clr_stat)           irq <= 1'b0;
    end
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_load && count > ONE) |=> count == $past(count) - ONE);
  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(count) == ONE && $past(ctrl.irq_en)));
  // R6
  zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_load && count == '0) |=> count == $past(reload));
  // R7
  zero_stuck_chk: assert property (@(posedge clk) disable iff (rst)
    (reload == '0 && count == '0 && !bus_load) |=> (count == '0 && !$rose(irq)));
  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stat && !(tick && count == ONE)) |=> !irq);
endmodule

// File: rtl/tmr_apb_regs.sv
module tmr_apb_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] reload,
  input  logic              irq,
  output tmr_ctrl_t         ctrl,
  output logic              wr_count,
  output logic              wr_reload,
  output logic              clr_stat,
  output logic [DATA_W-1:0] wdata
);
  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);
  localparam logic [ADDR_W-3:0] ID_FIRST = OFS_ID_LO[ADDR_W-1:2];

  logic              wr_acc;
  logic              rd_setup;
  logic              aligned;
  logic              is_id;
  logic [ADDR_W-1:0] id_off;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_acc    = psel & penable & pwrite;
    rd_setup  = psel & ~penable & ~pwrite;
    aligned   = (paddr[1:0] == 2'b00);
    is_id     = aligned & (paddr[ADDR_W-1:2] >= ID_FIRST);
    id_off    = paddr - OFS_ID_LO;
    wr_count  = wr_acc & (paddr == OFS_COUNT);
    wr_reload = wr_acc & (paddr == OFS_RELOAD);
    clr_stat  = wr_acc & (paddr == OFS_STAT) & pwdata[0];
    wdata     = pwdata;
    rd_mux    = '0;
    if (is_id) begin
      rd_mux[7:0] = id_byte(id_off[5:2]);
    end else begin
      case (paddr)
        OFS_CTRL:   rd_mux[CTRL_W-1:0] = ctrl;
        OFS_COUNT:  rd_mux = count;
        OFS_RELOAD: rd_mux = reload;
        OFS_STAT:   rd_mux[0] = irq;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      prdata <= '0;
    end else begin
      if (wr_acc && paddr == OFS_CTRL) ctrl <= tmr_ctrl_t'(pwdata[CTRL_W-1:0]);
      if (rd_setup) prdata <= rd_mux;
    end
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_acc && paddr == OFS_CTRL) |=> $stable(ctrl));
  // R11
  id_no_side_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && is_id) |-> !(wr_count || wr_reload || clr_stat));
endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq
);
  tmr_ctrl_t         ctrl;
  logic              ext_lvl;
  logic              ext_rise;
  logic              wr_count;
  logic              wr_reload;
  logic              clr_stat;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] reload;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ext_in(ext_in),
    .ext_lvl(ext_lvl), .ext_rise(ext_rise)
  );

  tmr_apb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .count(count), .reload(reload), .irq(irq),
    .ctrl(ctrl), .wr_count(wr_count), .wr_reload(wr_reload),
    .clr_stat(clr_stat), .wdata(wdata)
  );

  tmr_count_core #(.CNT_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .ext_lvl(ext_lvl), .ext_rise(ext_rise),
    .wr_count(wr_count), .wr_reload(wr_reload), .clr_stat(clr_stat),
    .wdata(wdata), .count(count), .reload(reload), .irq(irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && count == '0 && reload == '0));
  // R12
  bus_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (pready && !pslverr));
endmodule

// File: tb/sim_apb_interval_timer.sv
module sim_apb_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  logic        ext_in = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  apb_interval_timer u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read access phase
  always @(posedge clk) begin
    if (psel && penable && !pwrite) begin
      #2;
      if (exp_q.size() == 0) begin
        check("scoreboard", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk);
    @(negedge clk) penable = 1'b1;
    @(posedge clk);
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(posedge clk);
    @(negedge clk) penable = 1'b1;
    @(posedge clk);
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic wait_neg(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    wait_neg(3);
    rst = 1'b0;
    wait_neg(1);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    apb_rd(12'h000, 32'd0, "R1 ctrl");
    apb_rd(12'h004, 32'd0, "R1 count");
    apb_rd(12'h008, 32'd0, "R1 reload");
    apb_rd(12'h00C, 32'd0, "R1 status");
    check("R12 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    // R11 id bytes
    apb_rd(12'hFD0, 32'h04, "R11 id0");
    apb_rd(12'hFE4, 32'hB8, "R11 id5");
    apb_rd(12'hFE8, 32'h1B, "R11 id6");
    apb_rd(12'hFF4, 32'hF0, "R11 id9");
    apb_rd(12'hFFC, 32'hB1, "R11 id11");
    apb_wr(12'hFD0, 32'hFFFF_FFFF);
    apb_rd(12'hFD0, 32'h04, "R11 write ignored");
    apb_rd(12'h004, 32'd0, "R11 write no side effect");
    // R12 unmapped
    apb_wr(12'h010, 32'h1234_5678);
    apb_rd(12'h010, 32'd0, "R12 unmapped");
    apb_rd(12'h006, 32'd0, "R12 unaligned");
    apb_rd(12'h000, 32'd0, "R12 write ignored");
    // R2 ctrl bits
    apb_wr(12'h000, 32'hFFFF_FFF0);
    apb_rd(12'h000, 32'd0, "R2 upper bits");
    apb_wr(12'h000, 32'h0000_0006);
    apb_rd(12'h000, 32'd6, "R2 stored bits");
    apb_wr(12'h000, 32'd0);
    // R4 reload and count writes
    apb_wr(12'h008, 32'd5);
    apb_rd(12'h004, 32'd5, "R4 reload loads count");
    apb_wr(12'h004, 32'd9);
    apb_rd(12'h004, 32'd9, "R4 count write");
    apb_rd(12'h008, 32'd5, "R4 reload kept");
    // R3 free running
    apb_wr(12'h008, 32'd100);
    apb_wr(12'h000, 32'h1);
    wait_neg(10);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h004, 32'd88, "R3 free-run count");
    check("R5 no irq when disabled", {31'd0, irq}, 32'd0);
    // R5 R6 interrupt and period
    apb_wr(12'h008, 32'd3);
    apb_wr(12'h000, 32'h9);
    n = 0;
    while (!irq && n < 50) begin @(negedge clk); n++; end
    check("R5 ticks to irq", n, 32'd3);
    apb_rd(12'h00C, 32'd1, "R10 status reads 1");
    apb_wr(12'h00C, 32'd0);
    check("R10 write 0 no clear", {31'd0, irq}, 32'd1);
    n = 0;
    while (!irq && n < 50) begin @(negedge clk); n++; end
    apb_wr(12'h00C, 32'd1);
    check("R10 clear", {31'd0, irq}, 32'd0);
    n = 0;
    while (!irq && n < 50) begin @(negedge clk); n++; end
    check("R6 hold then reload", n, 32'd2);
    apb_wr(12'h000, 32'h0);
    apb_wr(12'h00C, 32'd1);
    check("R10 clear after stop", {31'd0, irq}, 32'd0);
    // R5 irq enable off
    apb_wr(12'h008, 32'd2);
    apb_wr(12'h000, 32'h1);
    wait_neg(12);
    check("R5 irq_en off", {31'd0, irq}, 32'd0);
    apb_wr(12'h000, 32'h0);
    // R7 reload zero
    apb_wr(12'h008, 32'd0);
    apb_wr(12'h000, 32'h9);
    wait_neg(20);
    check("R7 no irq", {31'd0, irq}, 32'd0);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h004, 32'd0, "R7 stays zero");
    // R10 same-cycle set and clear
    apb_wr(12'h008, 32'd5);
    apb_wr(12'h000, 32'h9);
    wait_neg(3);
    apb_wr(12'h00C, 32'd1);
    check("R10 set wins", {31'd0, irq}, 32'd1);
    apb_wr(12'h000, 32'h0);
    apb_wr(12'h00C, 32'd1);
    check("R10 later clear", {31'd0, irq}, 32'd0);
    // R8 external gate
    ext_in = 1'b0;
    wait_neg(5);
    apb_wr(12'h008, 32'd100);
    apb_wr(12'h000, 32'h3);
    wait_neg(10);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h004, 32'd100, "R8 gated low");
    ext_in = 1'b1;
    wait_neg(5);
    apb_wr(12'h008, 32'd100);
    apb_wr(12'h000, 32'h3);
    wait_neg(10);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h004, 32'd88, "R8 gated high");
    // R9 external clock
    ext_in = 1'b0;
    wait_neg(5);
    apb_wr(12'h008, 32'd100);
    apb_wr(12'h000, 32'h5);
    for (int i = 0; i < 4; i++) begin
      ext_in = 1'b1; wait_neg(3);
      ext_in = 1'b0; wait_neg(3);
    end
    wait_neg(4);
    apb_wr(12'h000, 32'h0);
    apb_rd(12'h004, 32'd96, "R9 edge count");
    wait_neg(4);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule